// File: doc/BRIEF.md
# Reservation Station Pool with Tag Wakeup

This block holds a few waiting instructions in front of one functional unit in an out-of-order core. Each issued instruction brings an opcode, a destination tag and two source operands. A source operand is either a value that is already known or the tag of the instruction that will produce it. All tags, destination and source alike, are reorder-buffer indices.

Every held entry watches a single result broadcast bus. When the broadcast tag equals a tag the entry is still waiting on, the entry takes that value. Once both operands are present the entry may be dispatched. Each cycle the oldest ready entry is offered to the functional unit. Age is the distance of the destination tag from the current reorder-buffer head, taken modulo the tag space.

A dispatched entry stays allocated until its own destination tag appears on the broadcast bus, and then it is released. A flush empties the whole pool at once. The functional unit is assumed to take every dispatched instruction.

Top module: `rs_pool`

## Requirements
- R1: After reset, `full_o` and `dispatch_valid_o` are both 0.
- R2: An issue is accepted only while `full_o` is 0, and it is placed in the lowest-numbered free entry. `full_o` is 1 exactly when all ENTRIES entries are held. An issue presented while `full_o` is 1 is dropped and is never dispatched.
- R3: An instruction issued with both operands marked ready (`*_rdy_i`=1) appears on the dispatch outputs in the cycle after issue, carrying its opcode, its destination tag and both values unchanged.
- R4: A pending operand (`*_rdy_i`=0) takes `cdb_value_i` when `cdb_valid_i` is 1 and `cdb_tag_i` equals its producer tag. The entry can dispatch in the cycle after that capture.
- R5: A broadcast in the same cycle as the issue, with a matching tag, is captured by the entry being issued.
- R6: When several entries are ready, the one whose `(dst - rob_head_i) mod 2^TAG_W` is smallest is dispatched first.
- R7: Each entry is dispatched exactly once. It stays held after dispatch and is released only when a broadcast carries its destination tag.
- R8: `flush_i` empties every entry in the next cycle, and it takes priority over an issue in the same cycle.
- R9: A broadcast whose tag matches no pending operand leaves every waiting operand pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty all entries |
| rob_head_i | input | TAG_W | Current reorder-buffer head index, used for age |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | OP_W | Opcode |
| issue_dst_i | input | TAG_W | Destination reorder-buffer index |
| issue_a_rdy_i | input | 1 | Operand A holds a value |
| issue_a_tag_i | input | TAG_W | Producer tag of operand A |
| issue_a_val_i | input | DATA_W | Value of operand A |
| issue_b_rdy_i | input | 1 | Operand B holds a value |
| issue_b_tag_i | input | TAG_W | Producer tag of operand B |
| issue_b_val_i | input | DATA_W | Value of operand B |
| full_o | output | 1 | No free entry |
| cdb_valid_i | input | 1 | Broadcast valid |
| cdb_tag_i | input | TAG_W | Broadcast tag |
| cdb_value_i | input | DATA_W | Broadcast value |
| dispatch_valid_o | output | 1 | An instruction is dispatched this cycle |
| dispatch_op_o | output | OP_W | Dispatched opcode |
| dispatch_dst_o | output | TAG_W | Dispatched destination tag |
| dispatch_a_o | output | DATA_W | Dispatched operand A |
| dispatch_b_o | output | DATA_W | Dispatched operand B |

## Verification
Faults in the held state show up at the ports within one or two cycles. A missed wakeup leaves `dispatch_valid_o` low in the cycle after the matching broadcast. A wrong capture puts a bad value on `dispatch_a_o` or `dispatch_b_o` at the next dispatch. A broken age comparison changes the order of destination tags seen across consecutive dispatch cycles. A bad release or flush shows up as `full_o` staying high or dropping one cycle too early, or as a dropped instruction appearing at dispatch.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  rob_head_i,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [TAG_W-1:0]  issue_dst_i,
  input  logic              issue_a_rdy_i,
  input  logic [TAG_W-1:0]  issue_a_tag_i,
  input  logic [DATA_W-1:0] issue_a_val_i,
  input  logic              issue_b_rdy_i,
  input  logic [TAG_W-1:0]  issue_b_tag_i,
  input  logic [DATA_W-1:0] issue_b_val_i,
  output logic              full_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_value_i,
  output logic              dispatch_valid_o,
  output logic [OP_W-1:0]   dispatch_op_o,
  output logic [TAG_W-1:0]  dispatch_dst_o,
  output logic [DATA_W-1:0] dispatch_a_o,
  output logic [DATA_W-1:0] dispatch_b_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] busy_q, sent_q, a_rdy_q, b_rdy_q, ready;
  logic [OP_W-1:0]    op_q  [ENTRIES];
  logic [TAG_W-1:0]   dst_q [ENTRIES];
  logic [TAG_W-1:0]   a_tag_q [ENTRIES];
  logic [TAG_W-1:0]   b_tag_q [ENTRIES];
  logic [DATA_W-1:0]  a_val_q [ENTRIES];
  logic [DATA_W-1:0]  b_val_q [ENTRIES];
  logic [TAG_W-1:0]   age [ENTRIES];

  logic [IDX_W-1:0] alloc_idx, sel_idx;
  logic             free_found, sel_found;
  logic [TAG_W-1:0] best_age;
  logic             do_issue;
  logic             a_hit_new, b_hit_new;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ready[g] = busy_q[g] & ~sent_q[g] & a_rdy_q[g] & b_rdy_q[g];
    assign age[g]   = dst_q[g] - rob_head_i;
  end

  assign full_o    = &busy_q;
  assign do_issue  = issue_valid_i & ~full_o & ~flush_i;
  assign a_hit_new = cdb_valid_i & ~issue_a_rdy_i & (cdb_tag_i == issue_a_tag_i);
  assign b_hit_new = cdb_valid_i & ~issue_b_rdy_i & (cdb_tag_i == issue_b_tag_i);

  always_comb begin
    free_found = 1'b0;
    alloc_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!busy_q[i] && !free_found) begin
        free_found = 1'b1;
        alloc_idx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_found = 1'b0;
    sel_idx   = '0;
    best_age  = '1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ready[i] && (!sel_found || age[i] < best_age)) begin
        sel_found = 1'b1;
        sel_idx   = IDX_W'(i);
        best_age  = age[i];
      end
    end
  end

  assign dispatch_valid_o = sel_found;
  assign dispatch_op_o    = op_q[sel_idx];
  assign dispatch_dst_o   = dst_q[sel_idx];
  assign dispatch_a_o     = a_val_q[sel_idx];
  assign dispatch_b_o     = b_val_q[sel_idx];

  always_ff @(posedge clk_i) begin
    if (!rst_ni || flush_i) begin
      busy_q <= '0;
      sent_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (busy_q[i]) begin
          if (cdb_valid_i && !a_rdy_q[i] && cdb_tag_i == a_tag_q[i]) begin
            a_rdy_q[i] <= 1'b1;
            a_val_q[i] <= cdb_value_i;
          end
          if (cdb_valid_i && !b_rdy_q[i] && cdb_tag_i == b_tag_q[i]) begin
            b_rdy_q[i] <= 1'b1;
            b_val_q[i] <= cdb_value_i;
          end
          if (sel_found && sel_idx == IDX_W'(i))
            sent_q[i] <= 1'b1;
          if (cdb_valid_i && sent_q[i] && cdb_tag_i == dst_q[i]) begin
            busy_q[i] <= 1'b0;
            sent_q[i] <= 1'b0;
          end
        end else if (do_issue && alloc_idx == IDX_W'(i)) begin
          busy_q[i]  <= 1'b1;
          sent_q[i]  <= 1'b0;
          op_q[i]    <= issue_op_i;
          dst_q[i]   <= issue_dst_i;
          a_tag_q[i] <= issue_a_tag_i;
          b_tag_q[i] <= issue_b_tag_i;
          a_rdy_q[i] <= issue_a_rdy_i | a_hit_new;
          b_rdy_q[i] <= issue_b_rdy_i | b_hit_new;
          a_val_q[i] <= a_hit_new ? cdb_value_i : issue_a_val_i;
          b_val_q[i] <= b_hit_new ? cdb_value_i : issue_b_val_i;
        end
      end
    end
  end

  // R2: a full pool ignores issue
  a_r2_full_drops_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && issue_valid_i && !cdb_valid_i && !flush_i) |=> $stable(busy_q));

  // R8: flush empties the pool
  a_r8_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (busy_q == '0));

  // R7: a dispatched entry is marked so it cannot dispatch again
  a_r7_dispatch_marks_sent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dispatch_valid_o && !flush_i) |=> sent_q[$past(sel_idx)]);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R7: release only by a broadcast or a flush
    a_r7_release_by_cdb: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_q[g]) |-> $past(cdb_valid_i || flush_i));
  end
endmodule

// File: tb/rs_pool_bench.sv
module rs_pool_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, flush, iv, ar, br, full, cv, dv;
  logic [3:0]  head, op, dst, at, bt, ct, d_op, d_dst;
  logic [15:0] av, bv, cval, d_a, d_b;
  int checks = 0, fails = 0;

  rs_pool u_rs_pool (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .rob_head_i(head),
    .issue_valid_i(iv), .issue_op_i(op), .issue_dst_i(dst),
    .issue_a_rdy_i(ar), .issue_a_tag_i(at), .issue_a_val_i(av),
    .issue_b_rdy_i(br), .issue_b_tag_i(bt), .issue_b_val_i(bv),
    .full_o(full), .cdb_valid_i(cv), .cdb_tag_i(ct), .cdb_value_i(cval),
    .dispatch_valid_o(dv), .dispatch_op_o(d_op), .dispatch_dst_o(d_dst),
    .dispatch_a_o(d_a), .dispatch_b_o(d_b));

  // {op, dst, a, b}: fully ready instructions
  localparam logic [39:0] VEC [6] = '{
    {4'h1, 4'h0, 16'h0001, 16'h0002},
    {4'h2, 4'h1, 16'hFFFF, 16'h0000},
    {4'h3, 4'h2, 16'h1234, 16'hABCD},
    {4'hF, 4'h3, 16'h8000, 16'h7FFF},
    {4'h0, 4'h4, 16'h5A5A, 16'hA5A5},
    {4'h7, 4'h5, 16'h0F0F, 16'hF0F0}};

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
    #1;
  endtask

  task automatic idle;
    iv = 0; cv = 0; flush = 0;
  endtask

  task automatic issue(input logic [3:0] o, input logic [3:0] d,
                       input logic a_r, input logic [3:0] a_t, input logic [15:0] a_v,
                       input logic b_r, input logic [3:0] b_t, input logic [15:0] b_v);
    iv = 1; op = o; dst = d; ar = a_r; at = a_t; av = a_v; br = b_r; bt = b_t; bv = b_v;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [15:0] v);
    cv = 1; ct = t; cval = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; head = 0; idle();
    op = 0; dst = 0; ar = 0; br = 0; at = 0; bt = 0; av = 0; bv = 0; ct = 0; cval = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    chk("R1 full", full, 0);
    chk("R1 dispatch_valid", dv, 0);

    for (int k = 0; k < 6; k++) begin
      issue(VEC[k][39:36], VEC[k][35:32], 1, 0, VEC[k][31:16], 1, 0, VEC[k][15:0]);
      cyc(); idle();
      chk("R3 valid", dv, 1);
      chk("R3 op", d_op, VEC[k][39:36]);
      chk("R3 dst", d_dst, VEC[k][35:32]);
      chk("R3 a", d_a, VEC[k][31:16]);
      chk("R3 b", d_b, VEC[k][15:0]);
      cyc();
      chk("R7 once", dv, 0);
      bcast(VEC[k][35:32], 16'h0);
      cyc(); idle();
    end

    // R5: same-cycle wakeup at issue
    issue(4'h9, 4'h4, 0, 4'h5, 16'hDEAD, 1, 0, 16'h0007);
    bcast(4'h5, 16'h0100);
    cyc(); idle();
    chk("R5 valid", dv, 1);
    chk("R5 a", d_a, 16'h0100);
    chk("R5 b", d_b, 16'h0007);
    cyc();
    bcast(4'h4, 0);
    cyc(); idle();

    // R9 / R4: non-matching then matching broadcast
    issue(4'h3, 4'h7, 1, 0, 16'h0011, 0, 4'h6, 16'h0);
    cyc(); idle();
    chk("R4 waits", dv, 0);
    bcast(4'h8, 16'h4444);
    cyc(); idle();
    chk("R9 unmatched", dv, 0);
    bcast(4'h6, 16'h2222);
    cyc(); idle();
    chk("R4 valid", dv, 1);
    chk("R4 b", d_b, 16'h2222);
    chk("R4 a", d_a, 16'h0011);
    cyc();
    bcast(4'h7, 0);
    cyc(); idle();

    // R6: oldest first, head = 14
    head = 4'd14;
    issue(1, 4'd1, 0, 4'd9, 0, 1, 0, 1); cyc();
    issue(2, 4'd15, 0, 4'd9, 0, 1, 0, 2); cyc();
    issue(3, 4'd3, 0, 4'd9, 0, 1, 0, 3); cyc(); idle();
    bcast(4'd9, 16'h0099);
    cyc(); idle();
    chk("R6 first", d_dst, 4'd15);
    cyc();
    chk("R6 second", d_dst, 4'd1);
    cyc();
    chk("R6 third", d_dst, 4'd3);
    cyc();
    chk("R6 drained", dv, 0);
    bcast(4'd15, 0); cyc();
    bcast(4'd1, 0); cyc();
    bcast(4'd3, 0); cyc(); idle();
    head = 0;

    // R2 / R7: fill, drop issue while full, release
    for (int k = 0; k < 4; k++) begin
      issue(4'(k), 4'(k), 0, 4'd12, 0, 1, 0, 0);
      cyc();
    end
    idle();
    chk("R2 full", full, 1);
    issue(4'hE, 4'd8, 1, 0, 16'hBEEF, 1, 0, 16'hBEEF);
    cyc(); idle();
    chk("R2 still full", full, 1);
    bcast(4'd12, 16'h0C0C);
    cyc(); idle();
    for (int k = 0; k < 4; k++) begin
      chk("R2 order", d_dst, 4'(k));
      cyc();
    end
    chk("R2 dropped never dispatched", dv, 0);
    chk("R7 held after dispatch", full, 1);
    bcast(4'd2, 0);
    cyc(); idle();
    chk("R7 released", full, 0);

    // R8: flush with a simultaneous issue
    flush = 1;
    issue(4'h5, 4'd9, 1, 0, 1, 1, 0, 1);
    cyc(); idle();
    chk("R8 no dispatch", dv, 0);
    chk("R8 not full", full, 0);
    for (int k = 0; k < 3; k++) begin
      issue(4'h1, 4'(k), 0, 4'd13, 0, 0, 4'd13, 0);
      cyc();
    end
    idle();
    chk("R8 three held", full, 0);
    issue(4'h1, 4'd3, 0, 4'd13, 0, 0, 4'd13, 0);
    cyc(); idle();
    chk("R8 four held", full, 1);
    flush = 1;
    cyc(); idle();
    chk("R8 flushed", full, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule